// File: doc/BRIEF.md
# Shared Address/Data Bus Peripheral Register Interface

This block is a bus slave for a processor whose low address byte and data byte travel on the same 8-bit lane. An address-latch strobe marks the address phase: while the strobe is high the lane carries the address, and the block keeps it once the strobe drops. In the data phase that follows, an active-low write or read strobe moves one byte. A memory/register select input sends the access either to an internal 256-word by 8-bit RAM or to a small bank of peripheral registers.

The peripheral registers are simple storage stubs that stand in for the port and timer logic behind them. They are a command word, two 8-bit ports, a 6-bit port and a 14-bit timer count split into a low byte and a 6-bit high part. A device-enable input gates every access. Read data goes out on a separate output with its own output-enable, which models the tri-state drive of the shared lane. A one-hot register-select output shows which register the last enabled register access reached.

Top module: `mbus_periph_if`

## Requirements
- R1: A synchronous active-high `rst` clears the command register, both 8-bit ports, the 6-bit port, the timer count, `reg_sel` and `ad_oe` to zero. An all-zero command word means every port is an input and the timer is idle. The RAM contents are not cleared.
- R2: While `ale` is high the address is taken from `ad_in`. After `ale` falls, the last address seen with `ale` high is held, and later values on `ad_in` do not change the access target.
- R3: With `io_sel`=0 an access reaches a RAM of 256 words of 8 bits. Every latched address from 0x00 to 0xFF holds its own byte.
- R4: The same latched address reaches the RAM when `io_sel`=0 and the register bank when `io_sel`=1. A write to one space does not change the other.
- R5: With `io_sel`=1, latched address bits [2:0] select the register and bits [7:3] are ignored. The codes are 0 command, 1 port A, 2 port B, 3 port C, 4 timer low byte, 5 timer high part.
- R6: With `io_sel`=1, register codes 6 and 7 ignore writes and read as 0x00.
- R7: Port C keeps only write bits [5:0], and the timer high part keeps only bits [5:0]. Both read back with bits [7:6] as zero. `tmr_q` is {high part, low byte}.
- R8: While `dev_en` is low, writes change neither the RAM nor any register, and `ad_oe` stays low.
- R9: `ad_oe` is high in the cycle after a clock edge that sampled `dev_en`=1, `rd_n`=0, `wr_n`=1 and `ale`=0, and is low otherwise. When both strobes are low, the access is a write and the lane is not driven.
- R10: A write happens at each clock edge that samples `dev_en`=1, `wr_n`=0 and `ale`=0. It stores `ad_in` at the held address.
- R11: During an enabled read, `ad_out` shows the addressed byte in the same cycle that `ad_oe` rises.
- R12: `reg_sel` is zero or one-hot. Bit k is high in the cycle after an enabled register-space read or write to code k (k = 0 to 5). It stays zero for RAM accesses and for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_en | input | 1 | Device enable, gates all accesses |
| io_sel | input | 1 | 1 selects the register bank, 0 selects the RAM |
| ale | input | 1 | Address-latch strobe, high during the address phase |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Shared lane as seen by the block (address or write data) |
| ad_out | output | 8 | Read data for the shared lane |
| ad_oe | output | 1 | Drive enable for the shared lane |
| reg_sel | output | 6 | One-hot register select of the last register access |
| cmd_q | output | 8 | Command register contents |
| porta_q | output | 8 | Port A register |
| portb_q | output | 8 | Port B register |
| portc_q | output | 6 | Port C register |
| tmr_q | output | 14 | Timer count {high part, low byte} |

## Verification
The hardest case to reach is one where the lane changes after `ale` has fallen but before the strobe arrives. Only a held address keeps such an access on its target. The bench adds idle cycles with junk bytes on `ad_in` between the address and data phases, then checks that the write landed at the held address. It also checks that reads at the junk address return untouched data. Register aliasing is reached by writing with the upper address bits set. The overlap case with both strobes low is reached by asserting them together.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned NREG = 6;

  typedef enum logic [2:0] {
    RI_CMD = 3'd0,
    RI_PA  = 3'd1,
    RI_PB  = 3'd2,
    RI_PC  = 3'd3,
    RI_TLO = 3'd4,
    RI_THI = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic [AW-1:0] ad_in,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)      lat_q <= '0;
    else if (ale) lat_q <= ad_in;
  end

  // transparent while the strobe is high, held afterwards
  assign addr_o = ale ? ad_in : lat_q;

  a_r2_hold_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> lat_q == $past(ad_in));
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mbus_regbank.sv
module mbus_regbank
  import mbus_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PC_W  = 6,
  parameter int unsigned THI_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    cmd_q,
  output logic [DW-1:0]    pa_q,
  output logic [DW-1:0]    pb_q,
  output logic [PC_W-1:0]  pc_q,
  output logic [DW-1:0]    tlo_q,
  output logic [THI_W-1:0] thi_q
);
  logic [DW-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      pa_q  <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
      tlo_q <= '0;
      thi_q <= '0;
    end else if (wr_en) begin
      case (idx)
        RI_CMD:  cmd_q <= wdata;
        RI_PA:   pa_q  <= wdata;
        RI_PB:   pb_q  <= wdata;
        RI_PC:   pc_q  <= wdata[PC_W-1:0];
        RI_TLO:  tlo_q <= wdata;
        RI_THI:  thi_q <= wdata[THI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (idx)
      RI_CMD:  rd_d = cmd_q;
      RI_PA:   rd_d = pa_q;
      RI_PB:   rd_d = pb_q;
      RI_PC:   rd_d[PC_W-1:0] = pc_q;
      RI_TLO:  rd_d = tlo_q;
      RI_THI:  rd_d[THI_W-1:0] = thi_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  // R1: the command word is all zero right after reset
  a_r1_cmd_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cmd_q == '0);

  // R8: without a write the command word holds
  a_r8_cmd_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(cmd_q));
endmodule

// File: rtl/mbus_periph_if.sv
module mbus_periph_if
  import mbus_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned PC_W  = 6,
  parameter int unsigned THI_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_en,
  input  logic                io_sel,
  input  logic                ale,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [DW-1:0]       ad_in,
  output logic [DW-1:0]       ad_out,
  output logic                ad_oe,
  output logic [NREG-1:0]     reg_sel,
  output logic [DW-1:0]       cmd_q,
  output logic [DW-1:0]       porta_q,
  output logic [DW-1:0]       portb_q,
  output logic [PC_W-1:0]     portc_q,
  output logic [THI_W+DW-1:0] tmr_q
);
  logic [AW-1:0]    addr;
  logic             wr_en, rd_en, io_acc;
  logic [DW-1:0]    mem_rd, reg_rd;
  logic [DW-1:0]    tlo;
  logic [THI_W-1:0] thi;
  logic             io_q;
  logic [NREG-1:0]  sel_d;

  mbus_addr_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in[AW-1:0]), .addr_o(addr)
  );

  assign wr_en  = dev_en && !wr_n && !ale;
  assign rd_en  = dev_en && !rd_n && wr_n && !ale;
  assign io_acc = io_sel && (wr_en || rd_en);

  mbus_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(wr_en && !io_sel), .addr(addr), .wdata(ad_in), .rdata(mem_rd)
  );

  mbus_regbank #(.DW(DW), .PC_W(PC_W), .THI_W(THI_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en && io_sel), .idx(addr[2:0]),
    .wdata(ad_in), .rdata(reg_rd), .cmd_q(cmd_q), .pa_q(porta_q),
    .pb_q(portb_q), .pc_q(portc_q), .tlo_q(tlo), .thi_q(thi)
  );

  assign tmr_q = {thi, tlo};

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign sel_d[k] = io_acc && (addr[2:0] == 3'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_oe   <= 1'b0;
      io_q    <= 1'b0;
      reg_sel <= '0;
    end else begin
      ad_oe   <= rd_en;
      io_q    <= io_sel;
      reg_sel <= sel_d;
    end
  end

  assign ad_out = io_q ? reg_rd : mem_rd;

  a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(dev_en && !rd_n && wr_n && !ale));

  a_r12_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_sel));

  a_r6_gap_no_select: assert property (@(posedge clk) disable iff (rst)
    $past(io_acc && addr[2:0] >= 3'd6) |-> reg_sel == '0);

  a_r8_off_no_drive: assert property (@(posedge clk) disable iff (rst)
    !$past(dev_en) |-> !ad_oe);
endmodule

// File: tb/mbus_periph_if_tb.sv
module mbus_periph_if_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_en = 1'b0, io_sel = 1'b0, ale = 1'b0;
  logic        rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  ad_in = 8'h00;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [5:0]  reg_sel;
  logic [7:0]  cmd_q, porta_q, portb_q;
  logic [5:0]  portc_q;
  logic [13:0] tmr_q;
  int n_chk = 0, n_fail = 0;
  logic [7:0]  rv;

  always #2.5 clk = ~clk;

  mbus_periph_if u_dut (
    .clk(clk), .rst(rst), .dev_en(dev_en), .io_sel(io_sel), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_sel(reg_sel), .cmd_q(cmd_q), .porta_q(porta_q), .portb_q(portb_q),
    .portc_q(portc_q), .tmr_q(tmr_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input bit io, input logic [7:0] a, input int junk);
    @(negedge clk); io_sel = io; ale = 1'b1; ad_in = a;
    @(negedge clk); ale = 1'b0;
    for (int i = 0; i < junk; i++) begin
      ad_in = a ^ 8'h5C ^ 8'(i);
      @(negedge clk);
    end
  endtask

  task automatic bus_wr(input bit io, input logic [7:0] a, input logic [7:0] d, input int junk = 0);
    addr_phase(io, a, junk);
    ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  task automatic bus_rd(input bit io, input logic [7:0] a, output logic [7:0] d, input string tag);
    addr_phase(io, a, 0);
    ad_in = 8'hEE; rd_n = 1'b0;
    @(negedge clk);
    chk(ad_oe === 1'b1, tag, ad_oe, 1);
    d = ad_out;
    rd_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(cmd_q === 8'h00, "R1 cmd", cmd_q, 0);
    chk({porta_q, portb_q, portc_q, tmr_q} === '0, "R1 ports", porta_q, 0);
    chk(ad_oe === 1'b0 && reg_sel === 6'b0, "R1 oe/sel", ad_oe, 0);
  endtask

  task automatic t_ram();
    bus_wr(0, 8'h00, 8'hA1);
    bus_wr(0, 8'hFF, 8'h3C);
    bus_wr(0, 8'h5A, 8'h96);
    bus_rd(0, 8'h00, rv, "R11 oe"); chk(rv === 8'hA1, "R3 addr 00", rv, 8'hA1);
    bus_rd(0, 8'hFF, rv, "R11 oe"); chk(rv === 8'h3C, "R3 addr FF", rv, 8'h3C);
    bus_rd(0, 8'h5A, rv, "R11 oe"); chk(rv === 8'h96, "R11 addr 5A", rv, 8'h96);
    chk(reg_sel === 6'b0, "R12 ram no sel", reg_sel, 0);
  endtask

  task automatic t_latch();
    bus_wr(0, 8'h10, 8'h00);
    bus_wr(0, 8'h20, 8'h77, 3);   // junk seen after ale falls
    bus_rd(0, 8'h20, rv, "R2 oe"); chk(rv === 8'h77, "R2 held addr", rv, 8'h77);
    bus_rd(0, 8'h20 ^ 8'h5C, rv, "R2 oe"); chk(rv !== 8'h77, "R2 junk addr untouched", rv, 0);
    bus_rd(0, 8'h10, rv, "R10 oe"); chk(rv === 8'h00, "R10 write data", rv, 0);
  endtask

  task automatic t_steer();
    bus_wr(0, 8'h01, 8'h11);
    bus_wr(1, 8'h01, 8'h22);
    bus_rd(0, 8'h01, rv, "R4 oe"); chk(rv === 8'h11, "R4 ram", rv, 8'h11);
    bus_rd(1, 8'h01, rv, "R4 oe"); chk(rv === 8'h22, "R4 reg", rv, 8'h22);
  endtask

  task automatic t_regs();
    for (int k = 0; k < 6; k++) begin
      bus_wr(1, 8'hF8 | 8'(k), 8'h30 + 8'(k));
      chk(reg_sel === 6'(1 << k), "R12 write sel", reg_sel, 1 << k);
    end
    chk(cmd_q === 8'h30 && porta_q === 8'h31 && portb_q === 8'h32, "R5 outputs", cmd_q, 8'h30);
    chk(portc_q === 6'h33 && tmr_q === {6'h35, 8'h34}, "R5 pc/timer", tmr_q, {6'h35, 8'h34});
    for (int k = 0; k < 6; k++) begin
      bus_rd(1, 8'(k), rv, "R5 oe");
      chk(rv === 8'h30 + 8'(k), "R5 read", rv, 8'h30 + k);
      chk(reg_sel === 6'(1 << k), "R12 read sel", reg_sel, 1 << k);
    end
  endtask

  task automatic t_gap();
    bus_wr(1, 8'h06, 8'hAB);
    chk(reg_sel === 6'b0, "R6 sel", reg_sel, 0);
    bus_wr(1, 8'h07, 8'hCD);
    bus_rd(1, 8'h06, rv, "R6 oe"); chk(rv === 8'h00, "R6 read 6", rv, 0);
    bus_rd(1, 8'h07, rv, "R6 oe"); chk(rv === 8'h00, "R6 read 7", rv, 0);
    chk(cmd_q === 8'h30 && porta_q === 8'h31 && portb_q === 8'h32 && portc_q === 6'h33
        && tmr_q === {6'h35, 8'h34}, "R6 others unchanged", cmd_q, 8'h30);
  endtask

  task automatic t_narrow();
    bus_wr(1, 8'h03, 8'hFF);
    bus_wr(1, 8'h05, 8'hFF);
    bus_rd(1, 8'h03, rv, "R7 oe"); chk(rv === 8'h3F, "R7 port C", rv, 8'h3F);
    bus_rd(1, 8'h05, rv, "R7 oe"); chk(rv === 8'h3F, "R7 timer hi", rv, 8'h3F);
    chk(tmr_q === 14'h3F34, "R7 tmr_q", tmr_q, 14'h3F34);
  endtask

  task automatic t_disabled();
    dev_en = 1'b0;
    bus_wr(0, 8'h01, 8'hEE);
    bus_wr(1, 8'h00, 8'hEE);
    addr_phase(0, 8'h01, 0);
    rd_n = 1'b0;
    @(negedge clk);
    chk(ad_oe === 1'b0, "R8 no drive", ad_oe, 0);
    rd_n = 1'b1;
    dev_en = 1'b1;
    chk(cmd_q === 8'h30, "R8 cmd kept", cmd_q, 8'h30);
    bus_rd(0, 8'h01, rv, "R8 oe"); chk(rv === 8'h11, "R8 ram kept", rv, 8'h11);
  endtask

  task automatic t_oe();
    @(negedge clk);
    chk(ad_oe === 1'b0, "R9 idle", ad_oe, 0);
    addr_phase(0, 8'h40, 0);
    ad_in = 8'h99; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    chk(ad_oe === 1'b0, "R9 both strobes", ad_oe, 0);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk(ad_oe === 1'b0, "R9 after", ad_oe, 0);
    bus_rd(0, 8'h40, rv, "R9 oe"); chk(rv === 8'h99, "R9 overlap wrote", rv, 8'h99);
  endtask

  task automatic t_rst_again();
    bus_wr(1, 8'h00, 8'hC3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(cmd_q === 8'h00 && porta_q === 8'h00 && tmr_q === 14'h0, "R1 mid-run reset", cmd_q, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        dev_en = 1'b1;
        t_ram();
        t_latch();
        t_steer();
        t_regs();
        t_gap();
        t_narrow();
        t_disabled();
        t_oe();
        t_rst_again();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule